// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block produces the words of an audio InfoFrame for a display transmitter. Software or a link controller pulses `start_i` and supplies three values: the channel count, the sink's compact speaker-allocation byte and a flag that selects DisplayPort framing instead of HDMI framing. The block captures these values. It expands the speaker byte into a per-speaker mask and searches a prioritised table of 32 channel-allocation codes for the first usable one. It then emits the finished data-island words one slot at a time on a valid/ready stream into the packet word buffer.

In HDMI mode the block builds a header word and two payload words, and it closes the payload with a byte checksum. In DisplayPort mode the channel count and the allocation code share one payload word and no checksum is formed. The block always writes every slot of the buffer and fills the unused slots with zero. It clears the packet control bits when a build starts. It raises the enable bit and the transmit-frequency bit together when the last slot has been accepted.

Back-pressure rules: a slot is transferred on a clock edge where `word_valid_o` and `word_ready_i` are both high. While `word_ready_i` is low, the slot index and data are held unchanged. The sink may hold `word_ready_i` low for any number of cycles.

Top module: `aif_infoframe_builder`

## Requirements
- R1: Speaker byte bits expand as follows. Bit 0 gives front left and front right. Bit 1 gives the low-frequency speaker. Bit 2 gives front centre. Bit 3 gives rear left and rear right. Bit 4 gives rear centre. Bit 5 gives front left-centre and front right-centre. Bit 6 gives rear left-centre and rear right-centre. Bit 7 contributes nothing.
- R2: A build with a channel count of 2 or less uses allocation code 0 whatever the speaker byte holds.
- R3: For more than 2 channels, the block scans the entries in priority order: 0x00, 0x01, 0x02, 0x08, 0x09, 0x0A, 0x0B, 0x0F, 0x13, then all other codes from 0x03 to 0x1F in ascending order. It takes the first entry whose speaker count equals the channel count and whose speakers all lie inside the expanded sink mask. If no entry qualifies, the code is 0. The chosen code appears on `alloc_code_o` from the cycle after start until the next start.
- R4: HDMI layout. Slot 0 is 32'h000A0184. Slot 1 holds channels−1 in bits 10:8 and the checksum in bits 7:0. Slot 2 holds the allocation code in bits 7:0. All other bits of these slots are zero.
- R5: In HDMI mode, the twelve bytes of slots 0 to 2 sum to zero modulo 256.
- R6: DisplayPort layout. Slot 0 is 32'h001B8400. Slot 1 holds channels−1 in bits 2:0 and the allocation code in bits 31:24, with all other bits zero. Slot 2 is zero.
- R7: Slots go out in the order 0 to 7, one transfer each. Slots 3 to 7 carry zero.
- R8: While `word_valid_o` is high and `word_ready_i` is low, `word_slot_o` and `word_data_o` stay unchanged on the next cycle.
- R9: Accepting a start clears `ctrl_dip_en_o` and `ctrl_dip_freq_o`, and both stay low while busy. On the cycle after slot 7 is accepted, `done_o` pulses for one cycle and both control bits are high.
- R10: `busy_o` is high from the cycle after an accepted start until slot 7 is accepted. A start or an input change during that time has no effect on the words, the code or the flow, and it is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a build (accepted only when idle) |
| chan_count_i | input | 4 | Channel count, 1 to 8 |
| spk_alloc_i | input | 8 | Sink compact speaker-allocation byte |
| dp_mode_i | input | 1 | 1 = DisplayPort layout, 0 = HDMI layout |
| busy_o | output | 1 | Build in progress |
| alloc_code_o | output | 8 | Selected channel-allocation code |
| word_valid_o | output | 1 | Slot word available |
| word_ready_i | input | 1 | Buffer accepts the slot word |
| word_slot_o | output | 3 | Slot index of the current word |
| word_data_o | output | 32 | Slot word |
| done_o | output | 1 | One-cycle pulse after the final slot |
| ctrl_dip_en_o | output | 1 | Packet enable control bit |
| ctrl_dip_freq_o | output | 1 | Packet transmit-frequency control bit |

## Verification
An accepted start takes effect at the next rising edge. The bench samples busy, the cleared control bits and the allocation code at the falling edge that follows. A slot is offered combinationally from the registered slot counter. The bench sets ready and reads the slot at the same falling edge, so a transfer falls on the next rising edge. Done and the raised control bits are read one falling edge after the final transfer. The bench checks the next falling edge for the absence of a queued restart. The sweep covers every speaker byte for every channel count from 1 to 8 in both layouts, under a pseudo-random ready pattern. Every seventh build carries a disturbing start with altered inputs while busy.

// File: rtl/aif_pkg.sv
package aif_pkg;

  localparam int SPK_W  = 11;
  localparam int CODE_W = 5;

  // speaker bit positions inside the expanded mask
  localparam int SP_FL  = 0;
  localparam int SP_FR  = 1;
  localparam int SP_LFE = 2;
  localparam int SP_FC  = 3;
  localparam int SP_RL  = 4;
  localparam int SP_RR  = 5;
  localparam int SP_RC  = 6;
  localparam int SP_FLC = 7;
  localparam int SP_FRC = 8;
  localparam int SP_RLC = 9;
  localparam int SP_RRC = 10;

  typedef logic [SPK_W-1:0]  spk_mask_t;
  typedef logic [CODE_W-1:0] ca_code_t;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WRITE = 1'b1} seq_state_t;

  // code held by priority position i of the search
  function automatic ca_code_t ca_order(input int i);
    ca_code_t c;
    case (i)
      0: c = 5'h00;
      1: c = 5'h01;
      2: c = 5'h02;
      3: c = 5'h08;
      4: c = 5'h09;
      5: c = 5'h0A;
      6: c = 5'h0B;
      7: c = 5'h0F;
      8: c = 5'h13;
      default: begin
        if (i < 14)      c = CODE_W'(i - 6);
        else if (i < 17) c = CODE_W'(i - 2);
        else if (i < 20) c = CODE_W'(i - 1);
        else             c = CODE_W'(i);
      end
    endcase
    return c;
  endfunction

  // speakers occupied by an allocation code
  function automatic spk_mask_t ca_mask(input ca_code_t code);
    spk_mask_t m;
    m = '0;
    m[SP_FL]  = 1'b1;
    m[SP_FR]  = 1'b1;
    m[SP_LFE] = code[0];
    m[SP_FC]  = code[1];
    case (code[4:2])
      3'd1: m[SP_RC] = 1'b1;
      3'd2: begin m[SP_RL] = 1'b1; m[SP_RR] = 1'b1; end
      3'd3: begin m[SP_RL] = 1'b1; m[SP_RR] = 1'b1; m[SP_RC] = 1'b1; end
      3'd4: begin m[SP_RL] = 1'b1; m[SP_RR] = 1'b1; m[SP_RLC] = 1'b1; m[SP_RRC] = 1'b1; end
      3'd5: begin m[SP_FLC] = 1'b1; m[SP_FRC] = 1'b1; end
      3'd6: begin m[SP_FLC] = 1'b1; m[SP_FRC] = 1'b1; m[SP_RC] = 1'b1; end
      3'd7: begin m[SP_FLC] = 1'b1; m[SP_FRC] = 1'b1; m[SP_RL] = 1'b1; m[SP_RR] = 1'b1; end
      default: ;
    endcase
    return m;
  endfunction

  function automatic int mask_count(input spk_mask_t m);
    int n;
    n = 0;
    for (int k = 0; k < SPK_W; k++) n += int'(m[k]);
    return n;
  endfunction

endpackage

// File: rtl/aif_spk_expand.sv
module aif_spk_expand
  import aif_pkg::*;
(
  input  logic [7:0] byte_i,
  output spk_mask_t  mask_o
);

  always_comb begin
    mask_o         = '0;
    mask_o[SP_FL]  = byte_i[0];
    mask_o[SP_FR]  = byte_i[0];
    mask_o[SP_LFE] = byte_i[1];
    mask_o[SP_FC]  = byte_i[2];
    mask_o[SP_RL]  = byte_i[3];
    mask_o[SP_RR]  = byte_i[3];
    mask_o[SP_RC]  = byte_i[4];
    mask_o[SP_FLC] = byte_i[5];
    mask_o[SP_FRC] = byte_i[5];
    mask_o[SP_RLC] = byte_i[6];
    mask_o[SP_RRC] = byte_i[6];
    // byte_i[7] names no speaker
  end

endmodule

// File: rtl/aif_ca_search.sv
module aif_ca_search
  import aif_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int NUM_CA = 32
) (
  input  logic [CH_W-1:0] chan_i,
  input  spk_mask_t       sink_i,
  output ca_code_t        code_o
);

  logic [NUM_CA-1:0] hit;
  ca_code_t          code_tab [NUM_CA];

  for (genvar g = 0; g < NUM_CA; g++) begin : g_entry
    localparam ca_code_t  ENT_CODE = ca_order(g);
    localparam spk_mask_t ENT_MASK = ca_mask(ENT_CODE);
    localparam int        ENT_CNT  = mask_count(ENT_MASK);
    assign code_tab[g] = ENT_CODE;
    assign hit[g]      = (int'(chan_i) == ENT_CNT) && ((ENT_MASK & sink_i) == ENT_MASK);
  end

  // lowest priority position wins
  always_comb begin
    code_o = '0;
    for (int i = NUM_CA - 1; i >= 0; i--) begin
      if (hit[i]) code_o = code_tab[i];
    end
    if (chan_i <= CH_W'(2)) code_o = '0;
  end

endmodule

// File: rtl/aif_word_pack.sv
module aif_word_pack
  import aif_pkg::*;
#(
  parameter logic [7:0]  HDR_TYPE  = 8'h84,
  parameter logic [7:0]  HDR_VER   = 8'h01,
  parameter logic [7:0]  HDR_LEN   = 8'h0A,
  parameter logic [31:0] DP_HEADER = 32'h001B_8400,
  parameter int          IDX_W     = 3
) (
  input  logic             dp_i,
  input  logic [2:0]       ch_m1_i,
  input  ca_code_t         code_i,
  input  logic [IDX_W-1:0] slot_i,
  output logic [31:0]      hdr_o,
  output logic [31:0]      pay1_o,
  output logic [31:0]      pay2_o,
  output logic [31:0]      word_o
);

  logic [7:0] partial_sum;
  logic [7:0] cksum;

  assign partial_sum = HDR_TYPE + HDR_VER + HDR_LEN + {5'd0, ch_m1_i} + {3'd0, code_i};
  assign cksum       = 8'd0 - partial_sum;

  always_comb begin
    if (dp_i) begin
      hdr_o  = DP_HEADER;
      pay1_o = {3'd0, code_i, 21'd0, ch_m1_i};
      pay2_o = '0;
    end else begin
      hdr_o  = {8'h00, HDR_LEN, HDR_VER, HDR_TYPE};
      pay1_o = {21'd0, ch_m1_i, cksum};
      pay2_o = {24'd0, 3'd0, code_i};
    end
  end

  always_comb begin
    case (slot_i)
      IDX_W'(0): word_o = hdr_o;
      IDX_W'(1): word_o = pay1_o;
      IDX_W'(2): word_o = pay2_o;
      default:   word_o = '0;
    endcase
  end

endmodule

// File: rtl/aif_seq.sv
module aif_seq
  import aif_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             done_o,
  output logic             dip_en_o,
  output logic             dip_freq_o
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] slot_q;
  logic             done_q, en_q, freq_q;
  logic             xfer;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign busy_o   = (state_q == ST_WRITE);
  assign valid_o  = busy_o;
  assign slot_o   = slot_q;
  assign done_o   = done_q;
  assign dip_en_o = en_q;
  assign dip_freq_o = freq_q;
  assign xfer     = valid_o && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      done_q  <= 1'b0;
      en_q    <= 1'b0;
      freq_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_WRITE;
            slot_q  <= '0;
            en_q    <= 1'b0;
            freq_q  <= 1'b0;
          end
        end
        default: begin
          if (xfer) begin
            if (slot_q == LAST_SLOT) begin
              state_q <= ST_IDLE;
              slot_q  <= '0;
              done_q  <= 1'b1;
              en_q    <= 1'b1;
              freq_q  <= 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(slot_o)); // R8
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && (slot_o != LAST_SLOT) |=> valid_o && (slot_o == $past(slot_o) + 1'b1)); // R7
  AST_CTRL_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !dip_en_o && !dip_freq_o); // R9
  AST_DONE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> dip_en_o && dip_freq_o && !busy_o); // R9
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && (slot_o == LAST_SLOT) |=> done_o && !busy_o); // R10

endmodule

// File: rtl/aif_infoframe_builder.sv
module aif_infoframe_builder
  import aif_pkg::*;
#(
  parameter int          CH_W      = 4,
  parameter int          NUM_SLOTS = 8,
  parameter logic [31:0] DP_HEADER = 32'h001B_8400,
  localparam int         IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_count_i,
  input  logic [7:0]       spk_alloc_i,
  input  logic             dp_mode_i,
  output logic             busy_o,
  output logic [7:0]       alloc_code_o,
  output logic             word_valid_o,
  input  logic             word_ready_i,
  output logic [IDX_W-1:0] word_slot_o,
  output logic [31:0]      word_data_o,
  output logic             done_o,
  output logic             ctrl_dip_en_o,
  output logic             ctrl_dip_freq_o
);

  logic [CH_W-1:0] chan_q;
  logic [7:0]      spk_q;
  logic            dp_q;
  logic            accept;
  spk_mask_t       sink_mask;
  ca_code_t        code;
  logic [CH_W-1:0] ch_m1;
  logic [31:0]     hdr_w, pay1_w, pay2_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      spk_q  <= '0;
      dp_q   <= 1'b0;
    end else if (accept) begin
      chan_q <= chan_count_i;
      spk_q  <= spk_alloc_i;
      dp_q   <= dp_mode_i;
    end
  end

  aif_spk_expand u_expand (
    .byte_i (spk_q),
    .mask_o (sink_mask)
  );

  aif_ca_search #(.CH_W(CH_W), .NUM_CA(32)) u_search (
    .chan_i (chan_q),
    .sink_i (sink_mask),
    .code_o (code)
  );

  assign ch_m1 = chan_q - 1'b1;

  aif_word_pack #(.DP_HEADER(DP_HEADER), .IDX_W(IDX_W)) u_pack (
    .dp_i    (dp_q),
    .ch_m1_i (ch_m1[2:0]),
    .code_i  (code),
    .slot_i  (word_slot_o),
    .hdr_o   (hdr_w),
    .pay1_o  (pay1_w),
    .pay2_o  (pay2_w),
    .word_o  (word_data_o)
  );

  aif_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ready_i    (word_ready_i),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .valid_o    (word_valid_o),
    .slot_o     (word_slot_o),
    .done_o     (done_o),
    .dip_en_o   (ctrl_dip_en_o),
    .dip_freq_o (ctrl_dip_freq_o)
  );

  assign alloc_code_o = {3'd0, code};

  logic [7:0] frame_sum;
  always_comb begin
    frame_sum = '0;
    for (int b = 0; b < 4; b++) begin
      frame_sum = frame_sum + hdr_w[b*8 +: 8] + pay1_w[b*8 +: 8] + pay2_w[b*8 +: 8];
    end
  end

  AST_CKSUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && !dp_q |-> frame_sum == 8'd0); // R5
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && (word_slot_o > IDX_W'(2)) |-> word_data_o == 32'd0); // R7
  AST_STEREO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (chan_q <= CH_W'(2)) |-> alloc_code_o == 8'd0); // R2
  AST_CODE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (alloc_code_o != 8'd0) |->
      ((ca_mask(alloc_code_o[4:0]) & sink_mask) == ca_mask(alloc_code_o[4:0])) &&
      (mask_count(ca_mask(alloc_code_o[4:0])) == int'(chan_q))); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(chan_q) && $stable(spk_q) && $stable(dp_q)); // R10

endmodule

// File: tb/tb_aif_infoframe_builder.sv
module tb_aif_infoframe_builder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  chan_count_i = '0;
  logic [7:0]  spk_alloc_i = '0;
  logic        dp_mode_i = 1'b0;
  logic        word_ready_i = 1'b0;
  logic        busy_o, word_valid_o, done_o, ctrl_dip_en_o, ctrl_dip_freq_o;
  logic [7:0]  alloc_code_o;
  logic [2:0]  word_slot_o;
  logic [31:0] word_data_o;

  int total = 0;
  int bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  aif_infoframe_builder dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_count_i(chan_count_i),
    .spk_alloc_i(spk_alloc_i), .dp_mode_i(dp_mode_i), .busy_o(busy_o),
    .alloc_code_o(alloc_code_o), .word_valid_o(word_valid_o),
    .word_ready_i(word_ready_i), .word_slot_o(word_slot_o),
    .word_data_o(word_data_o), .done_o(done_o), .ctrl_dip_en_o(ctrl_dip_en_o),
    .ctrl_dip_freq_o(ctrl_dip_freq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1 expansion of the sink byte
  function automatic logic [10:0] sink_of(input logic [7:0] b);
    logic [10:0] m = '0;
    if (b[0]) m |= 11'h003;
    if (b[1]) m |= 11'h004;
    if (b[2]) m |= 11'h008;
    if (b[3]) m |= 11'h030;
    if (b[4]) m |= 11'h040;
    if (b[5]) m |= 11'h180;
    if (b[6]) m |= 11'h600;
    return m;
  endfunction

  function automatic logic [10:0] spk_of(input logic [4:0] c);
    logic [10:0] m = 11'h003;
    if (c[0]) m |= 11'h004;
    if (c[1]) m |= 11'h008;
    case (c[4:2])
      3'd1: m |= 11'h040;
      3'd2: m |= 11'h030;
      3'd3: m |= 11'h070;
      3'd4: m |= 11'h630;
      3'd5: m |= 11'h180;
      3'd6: m |= 11'h1C0;
      3'd7: m |= 11'h1B0;
      default: ;
    endcase
    return m;
  endfunction

  function automatic bit early(input int c);
    return (c == 0) || (c == 1) || (c == 2) || (c == 8) || (c == 9) ||
           (c == 10) || (c == 11) || (c == 15) || (c == 19);
  endfunction

  function automatic logic [4:0] order_at(input int i);
    int n;
    case (i)
      0: return 5'h00; 1: return 5'h01; 2: return 5'h02;
      3: return 5'h08; 4: return 5'h09; 5: return 5'h0A;
      6: return 5'h0B; 7: return 5'h0F; 8: return 5'h13;
      default: ;
    endcase
    n = 9;
    for (int c = 0; c < 32; c++) begin
      if (!early(c)) begin
        if (n == i) return 5'(c);
        n++;
      end
    end
    return 5'h00;
  endfunction

  function automatic logic [4:0] exp_code(input int ch, input logic [7:0] b);
    logic [10:0] s = sink_of(b);
    if (ch <= 2) return 5'h00;
    for (int i = 0; i < 32; i++) begin
      logic [4:0] c = order_at(i);
      logic [10:0] m = spk_of(c);
      if (($countones(m) == ch) && ((m & s) == m)) return c;
    end
    return 5'h00;
  endfunction

  task automatic run_case(input bit dp, input int ch, input logic [7:0] b, input bit disturb);
    logic [4:0]  ca = exp_code(ch, b);
    logic [2:0]  m1 = 3'(ch - 1);
    logic [7:0]  ck = 8'(8'd0 - (8'h8F + {5'd0, m1} + {3'd0, ca}));
    logic [31:0] e [8];
    logic [31:0] got_w [8];
    logic [31:0] prev_d = '0;
    logic [2:0]  prev_s = '0;
    logic [7:0]  sum = '0;
    bit stall = 1'b0;
    int got = 0;
    int guard = 0;
    for (int k = 0; k < 8; k++) begin e[k] = '0; got_w[k] = '0; end
    if (dp) begin
      e[0] = 32'h001B8400;
      e[1] = {3'd0, ca, 21'd0, m1};
    end else begin
      e[0] = 32'h000A0184;
      e[1] = {21'd0, m1, ck};
      e[2] = {27'd0, ca};
    end
    @(negedge clk);
    start_i = 1'b1; chan_count_i = 4'(ch); spk_alloc_i = b; dp_mode_i = dp; word_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R10 busy after start", {31'd0, busy_o}, 32'd1);
    check(!ctrl_dip_en_o && !ctrl_dip_freq_o, "R9 ctrl cleared", {30'd0, ctrl_dip_en_o, ctrl_dip_freq_o}, 32'd0);
    check(alloc_code_o == {3'd0, ca}, (ch <= 2) ? "R2 stereo code" : "R1/R3 code search", {24'd0, alloc_code_o}, {27'd0, ca});
    if (disturb) begin
      start_i = 1'b1; chan_count_i = 4'(9 - ch); spk_alloc_i = ~b; dp_mode_i = ~dp;
      @(negedge clk);
      start_i = 1'b0;
      check(alloc_code_o == {3'd0, ca}, "R10 code kept while busy", {24'd0, alloc_code_o}, {27'd0, ca});
    end
    while (got < 8 && guard < 200) begin
      bit r;
      if (guard != 0 || disturb) @(negedge clk);
      guard++;
      if (stall) begin
        check(word_data_o == prev_d && word_slot_o == prev_s, "R8 hold under stall", word_data_o, prev_d);
      end
      r = lfsr[0] | lfsr[3];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      word_ready_i = r;
      check(word_valid_o == 1'b1, "R10 valid while building", {31'd0, word_valid_o}, 32'd1);
      if (word_valid_o) begin
        check(word_slot_o == 3'(got), "R7 slot order", {29'd0, word_slot_o}, got);
        check(word_data_o == e[got], (got > 2) ? "R7 zero pad" : (dp ? "R6 dp word" : "R4 hdmi word"),
              word_data_o, e[got]);
        got_w[got] = word_data_o;
        if (r) got++;
      end
      stall = word_valid_o && !r;
      prev_d = word_data_o;
      prev_s = word_slot_o;
    end
    if (got < 8) check(1'b0, "R7 all slots delivered", got, 8);
    @(negedge clk);
    word_ready_i = 1'b0;
    check(done_o == 1'b1, "R9 done pulse", {31'd0, done_o}, 32'd1);
    check(ctrl_dip_en_o && ctrl_dip_freq_o, "R9 ctrl set", {30'd0, ctrl_dip_en_o, ctrl_dip_freq_o}, 32'd3);
    check(busy_o == 1'b0, "R10 idle after last slot", {31'd0, busy_o}, 32'd0);
    if (!dp) begin
      for (int w = 0; w < 3; w++)
        for (int k = 0; k < 4; k++) sum = sum + got_w[w][k*8 +: 8];
      check(sum == 8'd0, "R5 checksum", {24'd0, sum}, 32'd0);
    end
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R10 no queued restart", {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !word_valid_o && !done_o && !ctrl_dip_en_o && !ctrl_dip_freq_o,
          "R9 reset state", {27'd0, busy_o, word_valid_o, done_o, ctrl_dip_en_o, ctrl_dip_freq_o}, 32'd0);
    rst_n = 1'b1;
    for (int dp = 0; dp < 2; dp++)
      for (int ch = 1; ch <= 8; ch++)
        for (int b = 0; b < 256; b++)
          run_case(dp[0], ch, 8'(b), ((b + ch) % 7) == 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule